// File: doc/BRIEF.md
# Dynamic Bus Sizing Transfer Sequencer

This block is the master-side engine that moves a single byte, word, three-byte or long-word operand between a requester and an external port whose width (8, 16 or 32 bits) is not known ahead of time. The width is learned only when the slave ends each bus cycle by driving a two-line size acknowledge. The sequencer works out how many bytes each cycle actually moved. It then advances the address and re-issues cycles until every operand byte has been transferred. Read bytes are gathered into a right-justified result.

The request side is a valid/ready stream. A request is taken on a clock edge where `req_valid` and `req_ready` are both high, and `req_ready` is high only while the block is idle. The response side is also valid/ready. `rsp_valid` rises once the last bus cycle has ended. It then holds with stable data until `rsp_ready` is seen high on a clock edge, and no new request is accepted before that edge. A requester can therefore stall the block for as long as it likes, and no bus activity happens while it does.

Operands may start on any byte address. The only exception is an instruction-fetch request, which must be word aligned. A misaligned fetch is answered with an error and produces no bus cycle.

Top module: `dbs_sequencer`

## Requirements
- R1: `req_ready` is 1 only when no transfer is in progress and no response is pending; while `bus_strobe` is high `req_ready` is 0.
- R2: During every bus cycle `bus_siz` gives the number of operand bytes not yet moved, encoded 01 = one, 10 = two, 11 = three, 00 = four; `req_size` uses the same encoding for the operand length.
- R3: The first bus cycle uses `req_addr`, and each later cycle's address is the previous address plus the bytes the previous cycle moved.
- R4: `bus_dsack_n` = 11 is a wait state: strobe stays high and `bus_addr`, `bus_siz` and `bus_wdata` hold unchanged into the next cycle.
- R5: An acknowledged cycle moves, from `n` remaining bytes at address `a`: min(n, 4 − a mod 4) for `bus_dsack_n` = 00 (32-bit port), min(n, 2 − a mod 2) for 01 (16-bit port), and 1 for 10 (8-bit port); the transfer takes exactly as many cycles as this rule implies.
- R6: Read data is big-endian. Lane 0 is `bus_rdata[31:24]`. A 32-bit port supplies the byte at address `a` on lane a mod 4, a 16-bit port on lane a mod 2, and an 8-bit port on lane 0. `rsp_rdata` holds the operand right-justified, with the lowest-addressed byte most significant.
- R7: On writes (`bus_rw` = 0), `req_wdata` is right-justified, with the lowest-addressed byte most significant. `bus_wdata` carries each pending byte on the lane that any of the three port widths would read it from, so every port width stores the correct bytes.
- R8: A request with `req_ifetch` = 1 and `req_addr[0]` = 1 produces no bus cycle. It gives a response with `rsp_err` = 1 on the cycle after acceptance. Fetches are always reads.
- R9: `rsp_valid` holds with stable `rsp_rdata` and `rsp_err` until `rsp_ready` is sampled high, and the bus stays idle meanwhile.
- R10: After reset `req_ready` = 1, `bus_strobe` = 0 and `rsp_valid` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_size | input | 2 | Operand length (01/10/11/00 = 1/2/3/4 bytes) |
| req_addr | input | ADDR_W | Byte address of the operand |
| req_write | input | 1 | 1 = write, 0 = read |
| req_ifetch | input | 1 | Instruction-fetch request (must be word aligned) |
| req_wdata | input | 32 | Right-justified write operand |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_rdata | output | 32 | Right-justified read operand |
| rsp_err | output | 1 | Misaligned fetch rejected |
| bus_addr | output | ADDR_W | Bus cycle address |
| bus_siz | output | 2 | Bytes still to move |
| bus_rw | output | 1 | 1 = read cycle, 0 = write cycle |
| bus_strobe | output | 1 | Bus cycle active |
| bus_wdata | output | 32 | Write data on byte lanes |
| bus_rdata | input | 32 | Read data from byte lanes |
| bus_dsack_n | input | 2 | Active-low size acknowledge (00/01/10 = 32/16/8-bit, 11 = wait) |

## Verification
The bench aims at long words that start at odd addresses on 16-bit and 8-bit ports, where the byte count per cycle changes from one cycle to the next. A sequencer that assumed a fixed width, or that ignored the starting offset, would issue the wrong number of cycles, or step to an address that skips or repeats bytes. Data is written through one port width and read back through another, so a write-lane replication error shows up as corrupted memory instead of passing unseen. Wait states, a three-byte operand, back-pressure on the response, and misaligned against aligned fetches are included as well. A design that let wait cycles move data, dropped a held response, or ran a rejected fetch on the bus would be caught.

// File: rtl/dbs_pkg.sv
package dbs_pkg;
  localparam int LANES  = 4;
  localparam int DATA_W = LANES * 8;

  localparam logic [1:0] ACK_P32  = 2'b00;
  localparam logic [1:0] ACK_P16  = 2'b01;
  localparam logic [1:0] ACK_P8   = 2'b10;
  localparam logic [1:0] ACK_WAIT = 2'b11;

  typedef enum logic [1:0] {ST_IDLE, ST_BUS, ST_RSP} dbs_state_e;

  typedef logic [LANES-1:0][7:0] byte_buf_t;

  // operand length in bytes from the two-bit size code (00 means four)
  function automatic logic [2:0] size_to_count(input logic [1:0] code);
    return (code == 2'b00) ? 3'd4 : {1'b0, code};
  endfunction
endpackage

// File: rtl/dbs_ack_decode.sv
module dbs_ack_decode
  import dbs_pkg::*;
(
  input  logic [1:0] ack_n,
  input  logic [1:0] addr_lo,
  input  logic [2:0] remain,
  output logic       ack_seen,
  output logic [2:0] moved,
  output logic [1:0] first_lane
);
  logic [2:0] room;

  always_comb begin
    ack_seen   = 1'b1;
    room       = 3'd0;
    first_lane = 2'd0;
    unique case (ack_n)
      ACK_P32: begin
        room       = 3'd4 - {1'b0, addr_lo};
        first_lane = addr_lo;
      end
      ACK_P16: begin
        room       = 3'd2 - {2'b00, addr_lo[0]};
        first_lane = {1'b0, addr_lo[0]};
      end
      ACK_P8: begin
        room       = 3'd1;
      end
      default: begin
        ack_seen   = 1'b0;
      end
    endcase
    moved = (remain < room) ? remain : room;
  end
endmodule

// File: rtl/dbs_wlane_mux.sv
module dbs_wlane_mux
  import dbs_pkg::*;
(
  input  byte_buf_t            op,
  input  logic [1:0]           base_k,
  input  logic [1:0]           addr_lo,
  output logic [DATA_W-1:0]    wdata
);
  for (genvar L = 0; L < LANES; L++) begin : g_lane
    logic [1:0] off;
    always_comb begin
      // widest port view first, then half-width view, otherwise the byte lane 0 copy
      if (2'(L) >= addr_lo)
        off = 2'(L) - addr_lo;
      else if (L < 2 && 2'(L) >= {1'b0, addr_lo[0]})
        off = 2'(L) - {1'b0, addr_lo[0]};
      else
        off = 2'd0;
    end
    assign wdata[(LANES-1-L)*8 +: 8] = op[base_k + off];
  end
endmodule

// File: rtl/dbs_sequencer.sv
module dbs_sequencer
  import dbs_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic              req_ifetch,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [1:0]        bus_siz,
  output logic              bus_rw,
  output logic              bus_strobe,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic [1:0]        bus_dsack_n
);
  dbs_state_e        state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [2:0]        rem_q;
  logic [2:0]        cnt_q;
  logic [1:0]        k_q;
  logic              rd_q;
  logic              err_q;
  byte_buf_t         op_q;

  logic              ack_seen;
  logic [2:0]        moved;
  logic [1:0]        first_lane;
  logic              accept;
  logic              bad_fetch;
  logic [2:0]        req_cnt;

  assign req_ready  = (state_q == ST_IDLE);
  assign rsp_valid  = (state_q == ST_RSP);
  assign bus_strobe = (state_q == ST_BUS);
  assign bus_addr   = addr_q;
  assign bus_siz    = rem_q[1:0];
  assign bus_rw     = rd_q;
  assign rsp_err    = err_q;

  assign accept    = req_valid && req_ready;
  assign bad_fetch = req_ifetch && req_addr[0];
  assign req_cnt   = size_to_count(req_size);

  dbs_ack_decode u_ack (
    .ack_n      (bus_dsack_n),
    .addr_lo    (addr_q[1:0]),
    .remain     (rem_q),
    .ack_seen   (ack_seen),
    .moved      (moved),
    .first_lane (first_lane)
  );

  dbs_wlane_mux u_wmux (
    .op      (op_q),
    .base_k  (k_q),
    .addr_lo (addr_q[1:0]),
    .wdata   (bus_wdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      rem_q   <= '0;
      cnt_q   <= '0;
      k_q     <= '0;
      rd_q    <= 1'b1;
      err_q   <= 1'b0;
      op_q    <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          addr_q <= req_addr;
          rem_q  <= req_cnt;
          cnt_q  <= req_cnt;
          k_q    <= 2'd0;
          rd_q   <= !req_write || req_ifetch;
          err_q  <= bad_fetch;
          for (int j = 0; j < LANES; j++) begin
            if (req_write && !req_ifetch && (j < int'(req_cnt)))
              op_q[j] <= req_wdata[(int'(req_cnt)-1-j)*8 +: 8];
            else
              op_q[j] <= 8'h00;
          end
          state_q <= bad_fetch ? ST_RSP : ST_BUS;
        end
        ST_BUS: if (ack_seen) begin
          if (rd_q) begin
            for (int j = 0; j < LANES; j++) begin
              if (3'(j) < moved)
                op_q[k_q + 2'(j)] <=
                  bus_rdata[(LANES-1-int'(first_lane + 2'(j)))*8 +: 8];
            end
          end
          addr_q <= addr_q + ADDR_W'(moved);
          rem_q  <= rem_q - moved;
          k_q    <= k_q + moved[1:0];
          if (moved == rem_q) state_q <= ST_RSP;
        end
        ST_RSP: if (rsp_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // right-justify the gathered operand, lowest address most significant
  always_comb begin
    rsp_rdata = '0;
    for (int j = 0; j < LANES; j++) begin
      if (j < int'(cnt_q))
        rsp_rdata[(int'(cnt_q)-1-j)*8 +: 8] = op_q[j];
    end
  end

  assert_wait_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_strobe && bus_dsack_n == ACK_WAIT) |=>
      (bus_strobe && $stable(bus_addr) && $stable(bus_siz) && $stable(bus_wdata)));

  assert_moved_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_strobe && bus_dsack_n != ACK_WAIT) |-> (moved != 3'd0 && moved <= rem_q));

  assert_bad_fetch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_ifetch && req_addr[0]) |=>
      (rsp_valid && rsp_err && !bus_strobe));

  assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=>
      (rsp_valid && $stable(rsp_rdata) && $stable(rsp_err) && !bus_strobe));
endmodule

// File: tb/dbs_sequencer_bench.sv
module dbs_sequencer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_size = 2'b00;
  logic [AW-1:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic        req_ifetch = 1'b0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_rdata;
  logic        rsp_err;
  logic [AW-1:0] bus_addr;
  logic [1:0]  bus_siz;
  logic        bus_rw;
  logic        bus_strobe;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata = '0;
  logic [1:0]  bus_dsack_n = 2'b11;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbs_sequencer #(.ADDR_W(AW)) u_dbs_sequencer (
    .clk, .rst_n, .req_valid, .req_ready, .req_size, .req_addr, .req_write,
    .req_ifetch, .req_wdata, .rsp_valid, .rsp_ready, .rsp_rdata, .rsp_err,
    .bus_addr, .bus_siz, .bus_rw, .bus_strobe, .bus_wdata, .bus_rdata, .bus_dsack_n
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  logic [7:0] mem_ref [64];
  logic [7:0] mem_dev [64];

  // scoreboard
  logic [31:0] q_data [$];
  bit          q_err  [$];
  bit          q_rd   [$];
  int          q_cyc  [$];
  string       q_tag  [$];

  // slave model state
  int port_w = 32;
  int wait_n = 0;
  int wait_cnt = 0;
  int exp_addr = 0;
  int exp_rem  = 0;
  int cyc_seen = 0;
  bit bp_mode  = 1'b0;
  int bp_cnt   = 0;

  function automatic int step_bytes(input int pw, input int a, input int rem);
    int room;
    room = (pw == 32) ? 4 - (a % 4) : (pw == 16) ? 2 - (a % 2) : 1;
    return (rem < room) ? rem : room;
  endfunction

  function automatic logic [7:0] lane_of(input logic [31:0] d, input int l);
    return d[(3-l)*8 +: 8];
  endfunction

  always @(posedge clk) begin
    bp_cnt  <= bp_cnt + 1;
    rsp_ready <= bp_mode ? (bp_cnt % 4 == 3) : 1'b1;
  end

  // slave: responds at the falling edge, design samples at the next rising edge
  always @(negedge clk) begin
    if (rst_n && bus_strobe) begin
      check(req_ready == 1'b0, "R1 ready low in bus cycle", {31'b0, req_ready}, 32'h0);
      if (wait_cnt < wait_n) begin
        if (wait_cnt > 0)
          check(bus_addr == AW'(exp_addr), "R4 address held in wait", bus_addr, exp_addr);
        wait_cnt++;
        bus_dsack_n <= 2'b11;
      end else begin
        int a, n, mv;
        a = int'(bus_addr);
        n = (bus_siz == 2'b00) ? 4 : int'(bus_siz);
        check(bus_addr == AW'(exp_addr), "R3 bus address", bus_addr, exp_addr);
        check(bus_siz == 2'(exp_rem), "R2 size outputs", {30'b0, bus_siz}, exp_rem);
        mv = step_bytes(port_w, a, n);
        if (port_w == 32) begin
          bus_dsack_n <= 2'b00;
          for (int l = 0; l < 4; l++) bus_rdata[(3-l)*8 +: 8] <= mem_dev[(a & ~3) + l];
          if (!bus_rw) for (int i = 0; i < mv; i++) mem_dev[a+i] = lane_of(bus_wdata, a%4 + i);
        end else if (port_w == 16) begin
          bus_dsack_n <= 2'b01;
          bus_rdata <= {mem_dev[a & ~1], mem_dev[(a & ~1) + 1], 16'h5AA5};
          if (!bus_rw) for (int i = 0; i < mv; i++) mem_dev[a+i] = lane_of(bus_wdata, a%2 + i);
        end else begin
          bus_dsack_n <= 2'b10;
          bus_rdata <= {mem_dev[a], 24'hC3C3C3};
          if (!bus_rw) mem_dev[a] = lane_of(bus_wdata, 0);
        end
        exp_addr = exp_addr + mv;
        exp_rem  = exp_rem - mv;
        cyc_seen++;
        wait_cnt = 0;
      end
    end else begin
      bus_dsack_n <= 2'b11;
    end
  end

  // monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (!rsp_ready) begin
        check(bus_strobe == 1'b0, "R9 bus idle while response held", {31'b0, bus_strobe}, 32'h0);
      end else if (q_tag.size() == 0) begin
        check(1'b0, "R9 unexpected response", rsp_rdata, 32'h0);
      end else begin
        logic [31:0] ed;
        bit ee, er;
        int ec;
        string t;
        ed = q_data.pop_front(); ee = q_err.pop_front(); er = q_rd.pop_front();
        ec = q_cyc.pop_front(); t = q_tag.pop_front();
        check(rsp_err == ee, {"R8 error flag ", t}, {31'b0, rsp_err}, {31'b0, ee});
        check(cyc_seen == ec, {"R5 cycle count ", t}, cyc_seen, ec);
        if (er && !ee) check(rsp_rdata == ed, {"R6 read data ", t}, rsp_rdata, ed);
      end
    end
  end

  task automatic run(input logic [1:0] sz, input int a, input bit wr,
                     input logic [31:0] wd, input bit fetch, input int pw,
                     input int wt, input string tag);
    int n, cyc, rem, ad;
    logic [31:0] ed;
    bit err;
    n   = (sz == 2'b00) ? 4 : int'(sz);
    err = fetch && a[0];
    ed  = '0;
    cyc = 0;
    if (!err) begin
      rem = n; ad = a;
      while (rem > 0) begin
        int mv;
        mv = step_bytes(pw, ad, rem);
        ad += mv; rem -= mv; cyc++;
      end
      if (wr && !fetch) begin
        for (int j = 0; j < n; j++) mem_ref[a+j] = wd[(n-1-j)*8 +: 8];
      end else begin
        for (int j = 0; j < n; j++) ed = (ed << 8) | 32'(mem_ref[a+j]);
      end
    end
    q_data.push_back(ed); q_err.push_back(err); q_rd.push_back(!wr || fetch);
    q_cyc.push_back(cyc); q_tag.push_back(tag);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    port_w = pw; wait_n = wt; wait_cnt = 0;
    exp_addr = a; exp_rem = n; cyc_seen = 0;
    req_size = sz; req_addr = AW'(a); req_write = wr; req_wdata = wd;
    req_ifetch = fetch; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin
      mem_ref[i] = 8'(i * 7 + 3);
      mem_dev[i] = 8'(i * 7 + 3);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, "R10 ready after reset", {31'b0, req_ready}, 32'h1);
    check(bus_strobe == 1'b0, "R10 strobe after reset", {31'b0, bus_strobe}, 32'h0);
    check(rsp_valid == 1'b0, "R10 no response after reset", {31'b0, rsp_valid}, 32'h0);

    run(2'b00, 8,  0, 0, 0, 32, 0, "long aligned p32");
    run(2'b00, 1,  0, 0, 0, 32, 0, "long addr1 p32");
    run(2'b00, 3,  0, 0, 0, 16, 1, "long addr3 p16");
    run(2'b10, 13, 0, 0, 0, 8,  0, "word odd p8");
    run(2'b01, 18, 0, 0, 0, 32, 2, "byte lane2 p32");
    run(2'b11, 21, 0, 0, 0, 32, 0, "three bytes p32");
    run(2'b00, 9,  1, 32'hA1B2C3D4, 0, 8,  2, "R7 long write p8");
    run(2'b00, 9,  0, 0, 0, 32, 0, "R7 readback p32");
    run(2'b10, 5,  1, 32'h0000E5F6, 0, 16, 0, "R7 word write p16");
    run(2'b00, 4,  0, 0, 0, 32, 1, "R7 readback word");
    run(2'b00, 14, 1, 32'h11223344, 0, 32, 0, "R7 long write p32 misaligned");
    run(2'b00, 14, 0, 0, 0, 16, 0, "R7 readback p16");
    run(2'b11, 29, 1, 32'h00778899, 0, 16, 0, "R7 three write p16");
    run(2'b00, 28, 0, 0, 0, 8,  0, "R7 readback p8");
    run(2'b10, 7,  0, 0, 1, 32, 0, "R8 misaligned fetch");
    run(2'b10, 40, 1, 32'h0000DEAD, 1, 16, 0, "R8 aligned fetch reads");
    bp_mode = 1'b1;
    run(2'b00, 33, 0, 0, 0, 32, 0, "R9 backpressure a");
    run(2'b00, 46, 0, 0, 0, 16, 1, "R9 backpressure b");
    run(2'b10, 51, 0, 0, 1, 8,  0, "R9 backpressure fetch err");
    bp_mode = 1'b0;
    run(2'b01, 30, 1, 32'h000000EE, 0, 8, 0, "R7 byte write p8");
    run(2'b10, 30, 0, 0, 0, 32, 0, "R7 readback byte");

    while (q_tag.size() != 0 && !finished) @(negedge clk);
    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule